// File: doc/BRIEF.md
# Vectored Interrupt Controller, 32 Sources

The controller collects up to 32 interrupt request lines, records each new request as a pending bit, and drives a single interrupt request line towards the processor whenever a pending source is also enabled. Software controls the enable mask with separate set and clear registers. It services an interrupt by reading the vector register. That one read returns the number of the lowest-numbered pending source, clears that source's pending bit, and records the number so that a later status read can return it again.

The register bus is word addressed. `bus_addr` carries the byte offset divided by four. Reads are combinational: `bus_rdata` is valid in the cycle in which `bus_rd` is high. Any side effect of a read or write takes hold at the next rising clock edge. Vector selection looks only at the pending bits and ignores the enable mask, so software may poll masked sources through the vector register.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the pending bits, the enable mask and the saved vector are all zero, and `irq` is low.
- R2: A pending bit is set on the cycle after a 0-to-1 transition of its request input. A request held high does not set the bit again after it has been cleared.
- R3: A read of word 0x40 (byte offset 0x100) returns, zero-extended, the index of the lowest-numbered pending bit. That bit is cleared at the same clock edge. The enable mask has no effect on which index is chosen.
- R4: A read of word 0x40 when no bit is pending returns 0 and changes no pending bit.
- R5: A read of word 0x42 (byte offset 0x108) returns the value given by the most recent read of word 0x40.
- R6: A read of word 0x44 (byte offset 0x110) returns the enable mask. A write to word 0x48 (byte offset 0x120) ORs the written data into the mask.
- R7: A write to word 0x49 (byte offset 0x124) clears from the mask every bit that is set in the written data.
- R8: A write to word 0x4A (byte offset 0x128) clears every pending bit that is set in the written data.
- R9: A write to word 0x4C (byte offset 0x130, end of interrupt) clears every pending bit that is set in the written data.
- R10: When a rising request and a clear of the same pending bit occur in the same cycle, the bit ends up set.
- R11: `irq` is a register. In any cycle it equals the OR of (pending AND mask) as that state stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address (byte offset / 4) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational, zero when no read |
| req_in | input | N | Interrupt request lines, one per source |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The bench raises every pair of sources in the same cycle and checks that vector reads return them lowest index first and then zero. A design with reversed priority or a clear that misses its bit would return the wrong index or the same index twice. A request held high must not return after its vector read, which catches a design that senses levels instead of edges. A clear that arrives in the same cycle as a new edge must lose; otherwise a request would be dropped. `irq` is sampled in the exact cycle it should change, both on a rise and after an end-of-interrupt write. This catches a combinational output or an extra register stage. It also checks that masked sources leave `irq` low but still show up in the vector.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int N      = 32,
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [N-1:0]      req_in,
  output logic              irq
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(8'h42);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(8'h44);
  localparam logic [ADDR_W-1:0] A_ESET = ADDR_W'(8'h48);
  localparam logic [ADDR_W-1:0] A_ECLR = ADDR_W'(8'h49);
  localparam logic [ADDR_W-1:0] A_PCLR = ADDR_W'(8'h4A);
  localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(8'h4C);

  logic [N-1:0]     req_q, pending, mask;
  logic [IDX_W-1:0] last_vec, idx;
  logic             hit;

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = N - 1; k >= 0; k--)
      if (pending[k]) begin
        hit = 1'b1;
        idx = IDX_W'(k);
      end
  end

  wire             vec_rd = bus_rd && (bus_addr == A_VEC);
  wire [N-1:0]     rise   = req_in & ~req_q;
  wire [N-1:0]     wclr   = (bus_wr && (bus_addr == A_PCLR || bus_addr == A_EOI))
                            ? bus_wdata[N-1:0] : '0;
  wire [N-1:0]     aclr   = (vec_rd && hit) ? (N'(1) << idx) : '0;
  wire [IDX_W-1:0] vec    = hit ? idx : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= '0;
      pending  <= '0;
      mask     <= '0;
      last_vec <= '0;
      irq      <= 1'b0;
    end else begin
      req_q   <= req_in;
      pending <= (pending & ~(wclr | aclr)) | rise;
      if (bus_wr && bus_addr == A_ESET) mask <= mask | bus_wdata[N-1:0];
      else if (bus_wr && bus_addr == A_ECLR) mask <= mask & ~bus_wdata[N-1:0];
      if (vec_rd) last_vec <= vec;
      irq <= |(pending & mask);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd)
      case (bus_addr)
        A_VEC:   bus_rdata = DW'(vec);
        A_LAST:  bus_rdata = DW'(last_vec);
        A_MASK:  bus_rdata = DW'(mask);
        default: bus_rdata = '0;
      endcase
  end
endmodule

module irq_vector_ctrl_chk #(
  parameter int N      = 32,
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic [N-1:0]      req_in,
  input logic [N-1:0]      req_q,
  input logic [N-1:0]      pending,
  input logic [N-1:0]      mask,
  input logic              irq
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  wire           vrd  = bus_rd && bus_addr == ADDR_W'(8'h40);
  wire [N-1:0]   sel  = N'(1) << bus_rdata[IDX_W-1:0];
  wire [N-1:0]   rise = req_in & ~req_q;

  p_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vrd && pending != '0) |-> ((pending & sel) != '0 && (pending & (sel - N'(1))) == '0));
  p_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vrd && pending != '0) |=> (pending & $past(sel) & ~$past(rise)) == '0);
  p_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vrd && pending == '0) |-> bus_rdata == '0);
  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(8'h48)) |=> (mask & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0]));
  p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(8'h49)) |=> (mask & $past(bus_wdata[N-1:0])) == '0);
  p_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> (pending & $past(rise)) == $past(rise));
  p_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|(pending & mask)));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.N(N), .ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_in(req_in), .req_q(req_q),
  .pending(pending), .mask(mask), .irq(irq));

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic        clk = 0, rst_n = 0, wr = 0, rd = 0, irq;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, req = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (.clk(clk), .rst_n(rst_n), .bus_addr(addr),
    .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata),
    .req_in(req), .irq(irq));

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", r, act, exp);
    end
  endtask

  task automatic bwr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic brd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic pulse(logic [31:0] p);
    @(negedge clk); req = p;
    @(negedge clk); req = '0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, m;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 irq", {31'b0, irq}, 0);
    brd(8'h44, d); chk("R1 mask", d, 0);
    brd(8'h42, d); chk("R1 saved", d, 0);
    brd(8'h40, d); chk("R1/R4 vec", d, 0);

    m = 0;
    for (int i = 0; i < 32; i++) begin
      bwr(8'h48, 32'h1 << i); m |= 32'h1 << i;
      brd(8'h44, d); chk("R6 set", d, m);
    end
    for (int i = 0; i < 32; i += 3) begin
      bwr(8'h49, 32'h5 << i); m &= ~(32'h5 << i);
      brd(8'h44, d); chk("R7 clr", d, m);
    end
    bwr(8'h48, 32'hFFFF_FFFF);

    for (int i = 0; i < 32; i++) begin
      pulse(32'h1 << i);
      chk("R11 not yet", {31'b0, irq}, 0);
      @(negedge clk); chk("R11 rise", {31'b0, irq}, 1);
      brd(8'h40, d); chk("R3 single", d, i);
      brd(8'h42, d); chk("R5 saved", d, i);
      @(negedge clk); chk("R11 fall", {31'b0, irq}, 0);
    end

    for (int i = 0; i < 32; i++)
      for (int j = i + 1; j < 32; j++) begin
        pulse((32'h1 << i) | (32'h1 << j));
        brd(8'h40, d); chk("R3 pair lo", d, i);
        brd(8'h40, d); chk("R3 pair hi", d, j);
        brd(8'h40, d); chk("R4 empty", d, 0);
        brd(8'h42, d); chk("R5 empty", d, 0);
      end

    bwr(8'h49, 32'hFFFF_FFFF);
    pulse(32'h20); @(negedge clk); @(negedge clk);
    chk("R11 masked", {31'b0, irq}, 0);
    brd(8'h40, d); chk("R3 mask ignored", d, 5);
    bwr(8'h48, 32'hFFFF_FFFF);

    @(negedge clk); req = 32'h80;
    repeat (3) @(negedge clk);
    brd(8'h40, d); chk("R2 held", d, 7);
    brd(8'h40, d); chk("R2 no reset", d, 0);
    req = 0; @(negedge clk);

    pulse(32'h212);
    bwr(8'h4A, 32'h202);
    brd(8'h40, d); chk("R8 pclr", d, 4);
    brd(8'h40, d); chk("R8 empty", d, 0);

    pulse(32'h44);
    bwr(8'h4C, 32'h4);
    brd(8'h40, d); chk("R9 eoi", d, 6);

    pulse(32'h400);
    @(negedge clk); chk("R11 pre eoi", {31'b0, irq}, 1);
    @(negedge clk); addr = 8'h4C; wdata = 32'h400; wr = 1;
    @(negedge clk); wr = 0; chk("R9 irq lag", {31'b0, irq}, 1);
    @(negedge clk); chk("R9 irq low", {31'b0, irq}, 0);

    @(negedge clk); req = 32'h8; addr = 8'h4A; wdata = 32'h8; wr = 1;
    @(negedge clk); wr = 0; req = 0;
    brd(8'h40, d); chk("R10 set wins", d, 3);
    @(negedge clk); req = 32'h8; addr = 8'h4C; wdata = 32'h8; wr = 1;
    @(negedge clk); wr = 0; req = 0;
    brd(8'h40, d); chk("R10 eoi", d, 3);

    pulse(32'h1);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R1 irq rst", {31'b0, irq}, 0);
    brd(8'h40, d); chk("R1 pend rst", d, 0);
    brd(8'h44, d); chk("R1 mask rst", d, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule